// File: doc/BRIEF.md
# Reduced-Pin Ethernet Receive/Transmit Adapter

This block sits between a 4-bit nibble data path on the MAC side and a 2-bit reduced-pin interface. A single reference clock times the interface, and every reference cycle moves one dibit. On receive, nibbles recovered from the line arrive on an enable strobe at their own pace. An elastic buffer holds them and a draining stage turns them into dibits, low-order pair first. Draining starts only after a programmable number of nibbles has built up, so that the buffer can absorb a small difference between the recovered rate and the reference rate. The design models the recovered side as an enable strobe in the reference clock domain.

The adapter drives one combined carrier-sense/data-valid output. It can end a packet in one of two ways. In the older mode the signal stays high until the final dibit has gone out. In the newer mode it alternates once carrier has dropped, so the MAC sees the loss of carrier while buffered data is still draining. A false carrier (line activity without a valid start of packet) is flagged by a fixed signature on the dibit lines. Buffer underflow and overflow set a sticky fault flag and raise receive error for the packet concerned. On transmit, successive dibit pairs are assembled into nibbles.

Top module: `rmii_adapter`

## Requirements
- R1: During draining, each buffered nibble leaves on rxDibit as two consecutive dibits: bits [1:0] first, then bits [3:2].
- R2: crsDv rises in the cycle right after inDv is first seen high. While the buffer is filling, before draining starts, rxDibit holds 2'b00 with crsDv high.
- R3: Draining starts once the buffer holds at least fillThresh nibbles (a value of 0 acts as 1), or once carrier is gone with data buffered. With one nibble every two cycles starting at the cycle after idle, the first data dibit appears 2*fillThresh+1 cycles after inDv first rises.
- R4: With rev10Mode=1, crsDv stays high through every drained dibit, including those sent after inDv has fallen.
- R5: With rev10Mode=0, after inDv has fallen, crsDv is 0 on each low-order dibit and 1 on each high-order dibit, until the buffer is empty.
- R6: In the cycle after the last dibit of a packet, crsDv, rxErr and rxDibit are all 0.
- R7: While idle, a high inFalseCar with inDv low gives crsDv=1, rxErr=1 and rxDibit=2'b10 from the next cycle. All three return to 0 in the cycle after inFalseCar falls.
- R8: If draining needs a nibble while the buffer is empty and carrier is still present (underflow), rxErr is raised for the rest of that packet and bufFault is set.
- R9: A nibble that arrives while the buffer is full, with no nibble leaving in the same cycle, is dropped (overflow). rxErr is raised for the rest of that packet and bufFault is set. The buffer never holds more than DEPTH nibbles.
- R10: bufFault stays set until reset. A later clean packet drains its data correctly with rxErr low.
- R11: With txEn high, each pair of successive txDibit values is assembled into a nibble, with the first dibit in bits [1:0]. txNibStb pulses for one cycle, with txNib valid, in the cycle after the second dibit is sampled.
- R12: When txEn falls after an odd number of dibits, the unpaired dibit is discarded, and pairing restarts with the next dibit sampled with txEn high.
- R13: After reset, crsDv, rxErr, rxDibit, bufFault and txNibStb are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one dibit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| rev10Mode | input | 1 | 1: crsDv held to the end; 0: crsDv alternates after carrier loss |
| fillThresh | input | CW | Nibbles to buffer before draining starts |
| inStb | input | 1 | A recovered nibble is present this cycle |
| inDv | input | 1 | Recovered carrier / packet active |
| inNib | input | 4 | Recovered nibble |
| inFalseCar | input | 1 | Line activity without a valid start delimiter |
| crsDv | output | 1 | Combined carrier-sense/data-valid |
| rxDibit | output | 2 | Receive dibit toward the MAC |
| rxErr | output | 1 | Receive error |
| bufFault | output | 1 | Sticky underflow/overflow flag |
| txEn | input | 1 | Transmit enable from the MAC |
| txDibit | input | 2 | Transmit dibit from the MAC |
| txNibStb | output | 1 | Assembled nibble valid |
| txNib | output | 4 | Assembled transmit nibble |

## Verification
The assertions take for granted that inDv and inFalseCar are never high together at the start of idle, that a packet is a single unbroken span of inDv, and that fillThresh and rev10Mode do not change while a packet is in flight. The stimulus changes the configuration only between packets, after the adapter has returned to idle. It keeps the two carrier inputs exclusive. It paces nibbles regularly, at the matched rate for clean packets and deliberately too slow or too fast to provoke underflow and overflow. Inputs change only on the falling clock edge.

// File: rtl/rmii_pkg.sv
package rmii_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FALSE = 2'd3
  } rxState_t;

  typedef struct packed {
    logic push;
    logic pop;
  } bufStb_t;

  localparam logic [1:0] FALSE_CAR_CODE = 2'b10;

endpackage

// File: rtl/rmii_datapath.sv
module rmii_datapath
  import rmii_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStb_t       stb,
  input  logic [3:0]    wrNib,
  output logic [CW-1:0] count,
  output logic [3:0]    headNib,
  output logic          ovfHit,
  input  logic          txEn,
  input  logic [1:0]    txDibit,
  output logic          txNibStb,
  output logic [3:0]    txNib
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [3:0]    store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          acceptPush;
  logic          txPhase;
  logic [1:0]    txLow;

  assign acceptPush = stb.push && ((count != FULL_CNT) || stb.pop);
  assign ovfHit     = stb.push && !acceptPush;
  assign headNib    = store[rdPtr];

  // one write-enabled register per buffer slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acceptPush && (wrPtr == AW'(i))) store[i] <= wrNib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (acceptPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (stb.pop)    rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(acceptPush) - CW'(stb.pop);
    end
  end

  // transmit dibit pairing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPhase  <= 1'b0;
      txLow    <= '0;
      txNibStb <= 1'b0;
      txNib    <= '0;
    end else begin
      txNibStb <= 1'b0;
      if (!txEn) begin
        txPhase <= 1'b0;
      end else if (!txPhase) begin
        txLow   <= txDibit;
        txPhase <= 1'b1;
      end else begin
        txNib    <= {txDibit, txLow};
        txNibStb <= 1'b1;
        txPhase  <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R9

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (count != '0)); // R1

  AST_TX_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    txNibStb |-> ($past(txEn) && $past(txEn, 2))); // R11

endmodule

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rev10Mode,
  input  logic [CW-1:0] fillThresh,
  input  logic          inStb,
  input  logic          inDv,
  input  logic          inFalseCar,
  input  logic [CW-1:0] count,
  input  logic [3:0]    headNib,
  input  logic          ovfHit,
  output bufStb_t       stb,
  output logic          crsDv,
  output logic [1:0]    rxDibit,
  output logic          rxErr,
  output logic          bufFault
);

  rxState_t   state, stateN;
  logic       phase, phaseN;
  logic       errPkt, errN;
  logic       crsN, rxErrN, faultSet, popN;
  logic [1:0] dibN;
  logic       bufHasData, threshMet, errAny;

  assign bufHasData = (count != '0);
  assign threshMet  = bufHasData && (count >= fillThresh);
  assign errAny     = errPkt || ovfHit;

  always_comb begin
    stb.push = inStb && inDv && (state != ST_FALSE);
    stb.pop  = popN;
  end

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    errN     = errPkt;
    crsN     = 1'b0;
    dibN     = 2'b00;
    rxErrN   = 1'b0;
    popN     = 1'b0;
    faultSet = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inDv) begin
          stateN = ST_FILL;
          errN   = 1'b0;
          phaseN = 1'b0;
          crsN   = 1'b1;
        end else if (inFalseCar) begin
          stateN = ST_FALSE;
          crsN   = 1'b1;
          rxErrN = 1'b1;
          dibN   = FALSE_CAR_CODE;
        end
      end
      ST_FALSE: begin
        if (inFalseCar && !inDv) begin
          crsN   = 1'b1;
          rxErrN = 1'b1;
          dibN   = FALSE_CAR_CODE;
        end else begin
          stateN = ST_IDLE;
        end
      end
      ST_FILL: begin
        crsN   = 1'b1;
        rxErrN = errAny;
        if (threshMet || (!inDv && bufHasData)) begin
          stateN = ST_DRAIN;
        end else if (!inDv) begin
          stateN = ST_IDLE;
          crsN   = 1'b0;
          rxErrN = 1'b0;
        end
      end
      ST_DRAIN: begin
        if (phase) begin
          dibN   = headNib[3:2];
          popN   = 1'b1;
          phaseN = 1'b0;
          crsN   = 1'b1;
          rxErrN = errAny;
        end else if (bufHasData) begin
          dibN   = headNib[1:0];
          phaseN = 1'b1;
          crsN   = inDv || rev10Mode;
          rxErrN = errAny;
        end else if (inDv) begin
          errN     = 1'b1;
          faultSet = 1'b1;
          crsN     = 1'b1;
          rxErrN   = 1'b1;
        end else begin
          stateN = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (ovfHit) begin
      errN     = 1'b1;
      faultSet = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      errPkt   <= 1'b0;
      crsDv    <= 1'b0;
      rxDibit  <= 2'b00;
      rxErr    <= 1'b0;
      bufFault <= 1'b0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      errPkt  <= errN;
      crsDv   <= crsN;
      rxDibit <= dibN;
      rxErr   <= rxErrN;
      if (faultSet) bufFault <= 1'b1;
    end
  end

  AST_CRS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && inDv) |=> crsDv); // R2

  AST_FALSE_SIG: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !inDv && inFalseCar) |=>
      (crsDv && rxErr && rxDibit == FALSE_CAR_CODE)); // R7

  AST_REV10_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && rev10Mode && count != '0) |=> crsDv); // R4

  AST_REV12_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !rev10Mode && !inDv && !phase && count != '0)
      |=> !crsDv); // R5

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bufFault |=> bufFault); // R10

  AST_UNDERFLOW_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !phase && count == '0 && inDv) |=> (rxErr && bufFault)); // R8

endmodule

// File: rtl/rmii_adapter.sv
module rmii_adapter
  import rmii_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rev10Mode,
  input  logic [CW-1:0] fillThresh,
  input  logic          inStb,
  input  logic          inDv,
  input  logic [3:0]    inNib,
  input  logic          inFalseCar,
  output logic          crsDv,
  output logic [1:0]    rxDibit,
  output logic          rxErr,
  output logic          bufFault,
  input  logic          txEn,
  input  logic [1:0]    txDibit,
  output logic          txNibStb,
  output logic [3:0]    txNib
);

  bufStb_t       bufStb;
  logic [CW-1:0] bufCount;
  logic [3:0]    headNib;
  logic          ovfHit;

  rmii_rx_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .rev10Mode(rev10Mode), .fillThresh(fillThresh),
    .inStb(inStb), .inDv(inDv), .inFalseCar(inFalseCar),
    .count(bufCount), .headNib(headNib), .ovfHit(ovfHit), .stb(bufStb),
    .crsDv(crsDv), .rxDibit(rxDibit), .rxErr(rxErr), .bufFault(bufFault)
  );

  rmii_datapath #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(bufStb), .wrNib(inNib),
    .count(bufCount), .headNib(headNib), .ovfHit(ovfHit),
    .txEn(txEn), .txDibit(txDibit), .txNibStb(txNibStb), .txNib(txNib)
  );

endmodule

// File: tb/sim_rmii_adapter.sv
module sim_rmii_adapter;
  localparam int DEPTH = 8;
  localparam int CW    = 4;
  localparam int NS    = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rev10Mode = 1'b0;
  logic [CW-1:0] fillThresh = '0;
  logic          inStb = 1'b0, inDv = 1'b0, inFalseCar = 1'b0;
  logic [3:0]    inNib = '0;
  logic          crsDv, rxErr, bufFault, txNibStb;
  logic [1:0]    rxDibit;
  logic          txEn = 1'b0;
  logic [1:0]    txDibit = '0;
  logic [3:0]    txNib;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [1:0] sD [NS];
  logic       sC [NS];
  logic       sE [NS];

  always #4 clk = ~clk;

  rmii_adapter #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .rev10Mode(rev10Mode), .fillThresh(fillThresh),
    .inStb(inStb), .inDv(inDv), .inNib(inNib), .inFalseCar(inFalseCar),
    .crsDv(crsDv), .rxDibit(rxDibit), .rxErr(rxErr), .bufFault(bufFault),
    .txEn(txEn), .txDibit(txDibit), .txNibStb(txNibStb), .txNib(txNib)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nibOf(input int j, input int t);
    return (j == 0) ? 4'h5 : 4'((j * 7 + t) & 15);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inDv = 0; inStb = 0; inFalseCar = 0; txEn = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one packet from iteration 1; sample at every iteration
  task automatic runPkt(input int n, input int period);
    int lim;
    lim = 4 * n * period + 40;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      sD[k] = rxDibit; sC[k] = crsDv; sE[k] = rxErr;
      if (k >= 1 && (k - 1) < n * period) begin
        inDv  = 1'b1;
        inStb = (((k - 1) % period) == 0);
        inNib = nibOf((k - 1) / period, int'(fillThresh));
      end else begin
        inDv = 1'b0; inStb = 1'b0;
      end
    end
  endtask

  task automatic checkClean(input int t, input int n, input bit r10);
    int ks, f, te;
    logic [3:0] nb;
    ks = -1;
    f = 1 + 2 * n;
    te = (t == 0) ? 1 : t;
    for (int k = 0; k < NS && ks < 0; k++) if (sD[k] != 2'b00) ks = k;
    chk(sC[1] == 1'b0 && sC[2] == 1'b1, "R2 crsDv rise", int'(sC[2]), 1);
    chk(ks == 2 * te + 2, "R3 drain start", ks, 2 * te + 2);
    if (ks < 0) ks = 2 * te + 2;
    for (int k = 2; k < ks; k++)
      chk(sC[k] == 1'b1 && sD[k] == 2'b00, "R2 fill hold", int'(sD[k]), 0);
    for (int j = 0; j < n; j++) begin
      nb = {sD[ks + 2 * j + 1], sD[ks + 2 * j]};
      chk(nb == nibOf(j, t), "R1 nibble", int'(nb), int'(nibOf(j, t)));
    end
    for (int j = 0; j < 2 * n; j++) begin
      int expC;
      expC = ((ks + j) < f + 1 || r10) ? 1 : (j % 2);
      chk(int'(sC[ks + j]) == expC, r10 ? "R4 crs hold" : "R5 crs toggle",
          int'(sC[ks + j]), expC);
      chk(sE[ks + j] == 1'b0, "R10 rxErr clean", int'(sE[ks + j]), 0);
    end
    chk(sC[ks + 2 * n] == 0 && sE[ks + 2 * n] == 0 && sD[ks + 2 * n] == 0,
        "R6 end quiet", int'(sC[ks + 2 * n]), 0);
  endtask

  function automatic bit errSeen(input int lim);
    for (int k = 0; k < lim; k++) if (sE[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic txSeq(input int m, input logic [1:0] dib [64], input logic en [64],
                       input logic expS [64], input logic [3:0] expN [64], input string req);
    for (int k = 0; k < m + 3; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        chk(txNibStb == expS[k], {req, " strobe"}, int'(txNibStb), int'(expS[k]));
        if (expS[k]) chk(txNib == expN[k], {req, " nibble"}, int'(txNib), int'(expN[k]));
      end
      if (k < m) begin txEn = en[k]; txDibit = dib[k]; end
      else txEn = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] dib [64];
    logic       en [64];
    logic       expS [64];
    logic [3:0] expN [64];

    doReset();
    @(negedge clk);
    chk(crsDv == 0 && rxErr == 0 && rxDibit == 0 && bufFault == 0 && txNibStb == 0,
        "R13 reset state", int'(crsDv) + int'(rxErr) + int'(bufFault), 0);

    // clean packets across thresholds and both end modes
    for (int r = 0; r < 2; r++) begin
      for (int t = 0; t <= 6; t++) begin
        doReset();
        rev10Mode = r[0]; fillThresh = CW'(t);
        runPkt(10, 2);
        checkClean(t, 10, r[0]);
      end
    end

    // false carrier
    doReset();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 1) chk(crsDv == 0 && rxErr == 0, "R7 before", int'(crsDv), 0);
      if (k >= 2 && k <= 6)
        chk(crsDv && rxErr && rxDibit == 2'b10, "R7 signature", int'(rxDibit), 2);
      if (k == 7) chk(!crsDv && !rxErr && rxDibit == 0, "R7 release", int'(rxDibit), 0);
      inFalseCar = (k >= 1 && k <= 5);
    end

    // underflow: slow arrivals
    doReset();
    rev10Mode = 0; fillThresh = 4'd1;
    runPkt(8, 3);
    chk(bufFault == 1'b1, "R8 fault", int'(bufFault), 1);
    chk(errSeen(4 * 8 * 3 + 40), "R8 rxErr", 0, 1);

    // overflow: fast arrivals
    doReset();
    fillThresh = 4'd8;
    runPkt(16, 1);
    chk(bufFault == 1'b1, "R9 fault", int'(bufFault), 1);
    chk(errSeen(4 * 16 + 40), "R9 rxErr", 0, 1);

    // sticky fault and clean follow-up packet
    fillThresh = 4'd2;
    runPkt(6, 2);
    checkClean(2, 6, 1'b0);
    chk(bufFault == 1'b1, "R10 sticky", int'(bufFault), 1);

    // transmit: every nibble value
    doReset();
    for (int k = 0; k < 64; k++) begin en[k] = 0; dib[k] = 0; expS[k] = 0; expN[k] = 0; end
    for (int j = 0; j < 16; j++) begin
      dib[2 * j] = 2'(j & 3); dib[2 * j + 1] = 2'(j >> 2);
      en[2 * j] = 1; en[2 * j + 1] = 1;
      if (2 * j + 2 < 64) begin expS[2 * j + 2] = 1; expN[2 * j + 2] = 4'(j); end
    end
    txSeq(32, dib, en, expS, expN, "R11");

    // transmit: odd dibit count discarded, pairing restarts
    for (int k = 0; k < 64; k++) begin en[k] = 0; dib[k] = 0; expS[k] = 0; expN[k] = 0; end
    dib[0] = 2'b01; dib[1] = 2'b10; dib[2] = 2'b11;
    en[0] = 1; en[1] = 1; en[2] = 1; en[3] = 0;
    dib[4] = 2'b10; dib[5] = 2'b01; en[4] = 1; en[5] = 1;
    expS[2] = 1; expN[2] = 4'b1001;
    expS[6] = 1; expN[6] = 4'b0110;
    txSeq(6, dib, en, expS, expN, "R12");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule